// File: doc/BRIEF.md
# Split Data-Space Decoder with Local Byte RAM

This block is the data-memory front end of a small 8-bit processor. The processor sees one flat byte address space, driven through a single address bus, a write-data bus, a write strobe and a read-data bus. The block divides that space on the address top bit. The lower half is served by a local byte-wide RAM inside the block. The upper half is handed to an external bank of IO registers through an exported port.

The exported port shares the processor's address and write data. The block only decides where a write strobe may go, and which source drives the read-data bus. Reads from the local RAM are combinational, so a load completes in the cycle that presents its address. A store lands on the next rising clock edge.

A synchronous, active-high reset keeps both write strobes low, so nothing can be written while it is held. It leaves the RAM contents as they are. A parameter chooses how the IO port sees the address: either an offset within the IO half, or the full bus address.

Top module: `mmio_data_port`

## Requirements
- R1: With address bit 7 equal to 0, the RAM is selected. It holds 128 independent bytes, indexed by address bits 6:0, so each of addresses 0 to 127 keeps its own value.
- R2: A RAM byte is written on the rising clock edge only when bus_we is 1, address bit 7 is 0 and rst is 0. During such a cycle io_we stays 0.
- R3: io_we is 1 exactly when bus_we is 1, address bit 7 is 1 and rst is 0. io_wdata carries bus_wdata. An IO write leaves the RAM byte that shares its low address bits unchanged.
- R4: A RAM read is combinational: bus_rdata shows the byte at the current address in the same cycle. In the cycle after a write, reading the same address returns the written value.
- R5: With address bit 7 equal to 1, bus_rdata equals io_rdata in the same cycle.
- R6: io_sel equals address bit 7. With the default IO_FULL_ADDR = 0, io_addr is {1'b0, address bits 6:0}. With IO_FULL_ADDR = 1, io_addr equals the full address.
- R7: While rst is 1, io_we is 0 and no RAM byte is written. RAM contents written before reset can still be read after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; RAM writes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks both write paths |
| bus_addr | input | ADDR_W | Byte address from the processor |
| bus_wdata | input | DATA_W | Store data from the processor |
| bus_we | input | 1 | Store strobe from the processor |
| bus_rdata | output | DATA_W | Load data returned to the processor |
| io_addr | output | ADDR_W | Address presented to the external IO registers |
| io_sel | output | 1 | High when the current address lies in the IO half |
| io_wdata | output | DATA_W | Store data presented to the IO registers |
| io_we | output | 1 | Store strobe to the IO registers |
| io_rdata | input | DATA_W | Load data from the IO registers |

## Verification
The bench builds the block with its default parameters: ADDR_W = 8, DATA_W = 8 and IO_FULL_ADDR = 0. With these values all 128 RAM bytes can be filled and read back in a few hundred cycles. The offset form of io_addr is the one exercised. The addresses 127 and 128 on either side of the split, and an IO address that aliases a RAM byte in its low bits, are all within reach.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

   typedef enum logic {
      TGT_RAM = 1'b0,
      TGT_IO  = 1'b1
   } tgt_e;

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
   import mmio_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter bit IO_FULL_ADDR = 1'b0,
   localparam int IDX_W       = ADDR_W - 1
)(
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output tgt_e              tgt,
   output logic [IDX_W-1:0]  ram_idx,
   output logic              ram_we,
   output logic              io_we,
   output logic [ADDR_W-1:0] io_addr
);

   always_comb begin
      tgt     = addr[ADDR_W-1] ? TGT_IO : TGT_RAM;
      ram_idx = addr[IDX_W-1:0];
      ram_we  = we && !rst && (tgt == TGT_RAM);
      io_we   = we && !rst && (tgt == TGT_IO);
   end

   generate
      if (IO_FULL_ADDR) begin : g_io_full
         assign io_addr = addr;
      end else begin : g_io_offset
         assign io_addr = {1'b0, addr[IDX_W-1:0]};
      end
   endgenerate

endmodule

// File: rtl/mmio_byte_ram.sv
module mmio_byte_ram #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 7,
   localparam int DEPTH = 1 << IDX_W
)(
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
   import mmio_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  tgt_e              tgt,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      unique case (tgt)
         TGT_IO:  rdata = io_rdata;
         default: rdata = ram_rdata;
      endcase
   end

endmodule

// File: rtl/mmio_data_port.sv
module mmio_data_port
   import mmio_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter bit IO_FULL_ADDR = 1'b0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] io_addr,
   output logic              io_sel,
   output logic [DATA_W-1:0] io_wdata,
   output logic              io_we,
   input  logic [DATA_W-1:0] io_rdata
);

   localparam int IDX_W = ADDR_W - 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr_w
         $error("mmio_data_port: ADDR_W must lie in 2..12");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("mmio_data_port: DATA_W must be at least 1");
      end
   endgenerate

   tgt_e              tgt;
   logic [IDX_W-1:0]  ram_idx;
   logic              ram_we;
   logic [DATA_W-1:0] ram_rdata;

   mmio_addr_decode #(
      .ADDR_W       (ADDR_W),
      .IO_FULL_ADDR (IO_FULL_ADDR)
   ) u_decode (
      .rst     (rst),
      .addr    (bus_addr),
      .we      (bus_we),
      .tgt     (tgt),
      .ram_idx (ram_idx),
      .ram_we  (ram_we),
      .io_we   (io_we),
      .io_addr (io_addr)
   );

   mmio_byte_ram #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .idx   (ram_idx),
      .wdata (bus_wdata),
      .rdata (ram_rdata)
   );

   mmio_rd_mux #(
      .DATA_W (DATA_W)
   ) u_rd_mux (
      .tgt       (tgt),
      .ram_rdata (ram_rdata),
      .io_rdata  (io_rdata),
      .rdata     (bus_rdata)
   );

   assign io_sel   = (tgt == TGT_IO);
   assign io_wdata = bus_wdata;

endmodule

// File: rtl/mmio_data_port_chk.sv
module mmio_data_port_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
)(
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_sel,
   input logic [DATA_W-1:0] io_wdata,
   input logic              io_we,
   input logic [DATA_W-1:0] io_rdata
);

   // R2: a store into the RAM half never raises the IO strobe
   assert_ram_store_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      !bus_addr[ADDR_W-1] |-> !io_we);

   // R3: the IO strobe only follows a store into the IO half
   assert_io_strobe_src_R3: assert property (@(posedge clk) disable iff (rst)
      io_we |-> (bus_we && bus_addr[ADDR_W-1] && io_wdata == bus_wdata));

   // R4: a written byte is read back in the following cycle
   assert_ram_readback_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(bus_we) && !$past(bus_addr[ADDR_W-1]) && !$past(rst)
       && !bus_addr[ADDR_W-1] && bus_addr == $past(bus_addr))
      |-> bus_rdata == $past(bus_wdata));

   // R5: the IO half returns the external read data
   assert_io_read_path_R5: assert property (@(posedge clk) disable iff (rst)
      bus_addr[ADDR_W-1] |-> bus_rdata == io_rdata);

   // R6: the select and the low address bits reach the IO port
   assert_io_addr_fwd_R6: assert property (@(posedge clk) disable iff (rst)
      io_sel == bus_addr[ADDR_W-1] && io_addr[ADDR_W-2:0] == bus_addr[ADDR_W-2:0]);

   // R7: no IO strobe while reset is held
   always_comb begin
      if (rst === 1'b1) begin
         assert_rst_no_strobe_R7: assert (io_we !== 1'b1);
      end
   end

endmodule

bind mmio_data_port mmio_data_port_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/mmio_data_port_bench.sv
`timescale 1ns/1ps
module mmio_data_port_bench;

   localparam int ADDR_W = 8;
   localparam int DATA_W = 8;

   typedef struct {
      logic [DATA_W-1:0] rdata;
      bit                chk_rd;
      logic              iowe;
      logic [ADDR_W-1:0] ioaddr;
      logic              iosel;
      logic [DATA_W-1:0] iowdata;
      string             tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic              bus_we;
   logic [DATA_W-1:0] bus_rdata;
   logic [ADDR_W-1:0] io_addr;
   logic              io_sel;
   logic [DATA_W-1:0] io_wdata;
   logic              io_we;
   logic [DATA_W-1:0] io_rdata;

   int   n_run  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];
   logic [DATA_W-1:0] ref_mem [128];

   always #2.5 clk = ~clk;

   mmio_data_port u_mmio_data_port (
      .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_we (bus_we), .bus_rdata (bus_rdata), .io_addr (io_addr),
      .io_sel (io_sel), .io_wdata (io_wdata), .io_we (io_we), .io_rdata (io_rdata)
   );

   task automatic drive(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        input logic we, input logic r, input logic [DATA_W-1:0] ird,
                        input bit chk_rd, input string tag);
      exp_t e;
      @(negedge clk);
      bus_addr = a; bus_wdata = wd; bus_we = we; rst = r; io_rdata = ird;
      e.rdata   = a[7] ? ird : ref_mem[a[6:0]];
      e.chk_rd  = chk_rd;
      e.iowe    = we & a[7] & ~r;
      e.ioaddr  = {1'b0, a[6:0]};
      e.iosel   = a[7];
      e.iowdata = wd;
      e.tag     = tag;
      if (we && !a[7] && !r) ref_mem[a[6:0]] = wd;
      sb_q.push_back(e);
   endtask

   task automatic check(input string tag, input string what,
                        input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: pops the expected item for each driven cycle, before the rising edge
   initial begin
      forever begin
         @(negedge clk);
         #1.5;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "io_we", {7'd0, io_we}, {7'd0, e.iowe});
            check(e.tag, "io_sel", {7'd0, io_sel}, {7'd0, e.iosel});
            check(e.tag, "io_addr", io_addr, e.ioaddr);
            if (e.iowe) check(e.tag, "io_wdata", io_wdata, e.iowdata);
            if (e.chk_rd) check(e.tag, "bus_rdata", bus_rdata, e.rdata);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 128; i++) ref_mem[i] = 'x;
      rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; io_rdata = '0;
      // R7: reset holds the IO strobe low even with an IO store requested
      drive(8'h90, 8'h11, 1'b1, 1'b1, 8'h00, 1'b0, "R7_rst_io");
      drive(8'h80, 8'h22, 1'b1, 1'b1, 8'h00, 1'b0, "R7_rst_io");
      // R2: RAM stores, edges of the lower half
      drive(8'h00, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b0, "R2_wr0");
      drive(8'h7F, 8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, "R2_wr127");
      drive(8'h05, 8'h3C, 1'b1, 1'b0, 8'h00, 1'b0, "R2_wr5");
      // R4 / R1: same-cycle read of stored bytes
      drive(8'h05, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R4_rd5");
      drive(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R1_rd0");
      drive(8'h7F, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R1_rd127");
      // R4: write then read next cycle
      drive(8'h33, 8'hC3, 1'b1, 1'b0, 8'h00, 1'b0, "R4_wr");
      drive(8'h33, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R4_rdnext");
      // R3: IO store aliasing RAM byte 5, then RAM byte 5 unchanged
      drive(8'h85, 8'hEE, 1'b1, 1'b0, 8'h77, 1'b1, "R3_io_wr");
      drive(8'h05, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R3_ram_kept");
      drive(8'hFF, 8'h01, 1'b1, 1'b0, 8'h10, 1'b1, "R3_io_wr255");
      // R5 / R6: IO reads with several responder values, boundary 128
      drive(8'h80, 8'h00, 1'b0, 1'b0, 8'h9D, 1'b1, "R5_io_rd128");
      drive(8'hC4, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R5_io_rd_zero");
      drive(8'hC4, 8'h00, 1'b0, 1'b0, 8'hFF, 1'b1, "R6_io_addr");
      // R7: RAM store attempted during reset is dropped, contents survive
      drive(8'h05, 8'h99, 1'b1, 1'b1, 8'h00, 1'b0, "R7_rst_ram");
      drive(8'h05, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R7_kept5");
      drive(8'h33, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R7_kept33");
      // R1: fill all 128 bytes, then read every one back
      for (int i = 0; i < 128; i++)
         drive(i[7:0], 8'(i * 37 + 11), 1'b1, 1'b0, 8'h00, 1'b0, "R1_fill");
      for (int i = 0; i < 128; i++)
         drive(i[7:0], 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, "R1_readall");
      drive(8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, "idle");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule